// File: doc/BRIEF.md
# Stereo Soft Mute Fader

This block is a digital attenuator inserted in the sample path ahead of a stereo DAC. A mute request makes the gain fall gradually from unity to silence, and withdrawing the request brings it back up to unity. The gain changes by one step per sample period, so a full fade in either direction takes 1024 sample periods. Sample-rate timing comes from a one-cycle frame strobe.

On each strobe the block scales the left and right 20-bit two's complement samples by the current gain and registers the results. It then moves the gain one step toward the target that the mute request selects. A request that changes in the middle of a fade turns the fade around from the level it has reached, with no jump. The gain curve is linear in amplitude. The products are rounded toward zero and clamped to the 20-bit range.

Top module: `smute_ramp`

## Requirements
- R1: After reset the internal gain is unity (1024) and both outputs are zero.
- R2: With the gain at unity, the outputs registered on a strobe edge equal the inputs presented with that strobe. They are visible from the clock edge that samples the strobe onwards.
- R3: While the mute request is high, each strobe lowers the gain by exactly one. Starting from unity the gain reaches 0 after 1024 strobes. The output on a strobe is trunc(input * g / 1024), where g is the gain before that strobe's step.
- R4: While the gain is 0 the outputs are exactly zero for any input, and the gain stays at 0 as long as the request is held.
- R5: While the mute request is low, each strobe raises the gain by one until it reaches 1024, where it stays. A full rise from 0 takes 1024 strobes.
- R6: Releasing the request partway down a fade makes the gain rise from the level reached, one step per strobe.
- R7: Raising the request partway up a rise makes the gain fall from the level reached, one step per strobe.
- R8: The division by 1024 rounds toward zero for negative products as well as positive ones (for example -3 at gain 512 gives -1), and the result is clamped to [-524288, 524287].
- R9: Left and right are scaled by the same gain independently of each other.
- R10: In cycles without a strobe, the gain and the outputs hold, whatever the request and the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mute_req | input | 1 | High requests a fade to silence, low a fade to unity |
| frame_tick | input | 1 | One-cycle strobe per sample period |
| l_in | input | 20 | Left input sample, two's complement |
| r_in | input | 20 | Right input sample, two's complement |
| l_out | output | 20 | Left attenuated sample, registered |
| r_out | output | 20 | Right attenuated sample, registered |

## Verification
The assertions check the following on every cycle: the single-step movement of the gain in each direction, its ceiling at unity, zero output at zero gain, exact passthrough at unity, and the absence of any change between strobes. The following can only be shown by the bench's scenarios: the exact product rounding of negative samples, that a fade takes 1024 strobes end to end, and the turnaround with no jump when the request flips mid-fade. The bench reads the gain through the outputs by feeding a sample of 2^18, so each output equals 256 times the gain.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_UP   = 2'd2
  } step_e;
endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
  parameter int RAMP_LEN = 1024,
  parameter int GW       = $clog2(RAMP_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mute,
  output logic [GW-1:0] gain
);
  import smr_pkg::*;

  localparam logic [GW-1:0] GMAX = GW'(RAMP_LEN);

  step_e         step;
  logic [GW-1:0] gain_q;
  logic [GW-1:0] gain_d;

  always_comb begin
    step = STEP_HOLD;
    if (mute && gain_q != '0)        step = STEP_DOWN;
    else if (!mute && gain_q != GMAX) step = STEP_UP;
    case (step)
      STEP_DOWN: gain_d = gain_q - 1'b1;
      STEP_UP:   gain_d = gain_q + 1'b1;
      default:   gain_d = gain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gain_q <= GMAX;
    else if (tick) gain_q <= gain_d;
  end

  assign gain = gain_q;
endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
  parameter int DW    = 20,
  parameter int GW    = 11,
  parameter int SHIFT = 10
) (
  input  logic [DW-1:0] samp,
  input  logic [GW-1:0] gain,
  output logic [DW-1:0] scaled
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] RND = {{(PW-SHIFT){1'b0}}, {SHIFT{1'b1}}};
  localparam logic signed [PW-1:0] HI  = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO  = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] biased;
  logic signed [PW-1:0] quot;

  always_comb begin
    prod   = $signed({{(GW+1){samp[DW-1]}}, samp}) * $signed({{(DW+1){1'b0}}, gain});
    biased = prod + (prod[PW-1] ? RND : '0);
    quot   = biased >>> SHIFT;
    if (gain == '0)       scaled = '0;
    else if (quot > HI)   scaled = HI[DW-1:0];
    else if (quot < LO)   scaled = LO[DW-1:0];
    else                  scaled = quot[DW-1:0];
  end
endmodule

// File: rtl/smute_ramp.sv
module smute_ramp #(
  parameter int DW       = 20,
  parameter int RAMP_LEN = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mute_req,
  input  logic          frame_tick,
  input  logic [DW-1:0] l_in,
  input  logic [DW-1:0] r_in,
  output logic [DW-1:0] l_out,
  output logic [DW-1:0] r_out
);
  localparam int SHIFT = $clog2(RAMP_LEN);
  localparam int GW    = SHIFT + 1;
  localparam int NCH   = 2;

  logic                    rst_meta;
  logic                    rst_sync_n;
  logic [GW-1:0]           gain_w;
  logic [NCH-1:0][DW-1:0]  in_v;
  logic [NCH-1:0][DW-1:0]  nxt_v;
  logic [NCH-1:0][DW-1:0]  out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  smr_gain_ctrl #(.RAMP_LEN(RAMP_LEN), .GW(GW)) gain_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (frame_tick),
    .mute (mute_req),
    .gain (gain_w)
  );

  assign in_v[0] = l_in;
  assign in_v[1] = r_in;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    smr_scale #(.DW(DW), .GW(GW), .SHIFT(SHIFT)) scale_i (
      .samp  (in_v[ch]),
      .gain  (gain_w),
      .scaled(nxt_v[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     out_q <= '0;
    else if (frame_tick) out_q <= nxt_v;
  end

  assign l_out = out_q[0];
  assign r_out = out_q[1];
endmodule

// File: rtl/smr_chk.sv
module smr_chk #(
  parameter int DW       = 20,
  parameter int GW       = 11,
  parameter int RAMP_LEN = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          mute,
  input logic [GW-1:0] gain,
  input logic [DW-1:0] l_in,
  input logic [DW-1:0] r_in,
  input logic [DW-1:0] l_out,
  input logic [DW-1:0] r_out
);
  localparam logic [GW-1:0] GMAX = GW'(RAMP_LEN);

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mute && gain != '0) |=> (gain == $past(gain) - 1'b1));

  // R5
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mute && gain != GMAX) |=> (gain == $past(gain) + 1'b1));

  // R5
  gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GMAX);

  // R4
  zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gain == '0) |=> (l_out == '0 && r_out == '0 && gain == '0 || !$past(mute)));

  // R2
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gain == GMAX) |=> (l_out == $past(l_in) && r_out == $past(r_in)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(gain) && $stable(l_out) && $stable(r_out)));
endmodule

bind smute_ramp smr_chk #(.DW(DW), .GW(GW), .RAMP_LEN(RAMP_LEN)) chk_i (
  .clk  (clk),
  .rst_n(rst_sync_n),
  .tick (frame_tick),
  .mute (mute_req),
  .gain (gain_w),
  .l_in (l_in),
  .r_in (r_in),
  .l_out(l_out),
  .r_out(r_out)
);

// File: tb/smute_ramp_tb.sv
module smute_ramp_tb_top;
  localparam int DW = 20;
  localparam int FULL = 1024;
  localparam int PROBE = 262144;

  logic          clk;
  logic          rst_n;
  logic          mute_req;
  logic          frame_tick;
  logic [DW-1:0] l_in;
  logic [DW-1:0] r_in;
  logic [DW-1:0] l_out;
  logic [DW-1:0] r_out;

  int checks = 0;
  int errors = 0;
  int mg = FULL;
  int cyc = 0;
  bit done = 0;

  smute_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .frame_tick(frame_tick),
    .l_in(l_in), .r_in(r_in), .l_out(l_out), .r_out(r_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int expect_of(int v, int g);
    int q;
    if (g == 0) return 0;
    q = (v * g) / FULL;
    if (q > 524287) q = 524287;
    if (q < -524288) q = -524288;
    return q;
  endfunction

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_chk(bit m, int lv, int rv, string req);
    int el, er;
    @(negedge clk);
    mute_req   = m;
    l_in       = lv[DW-1:0];
    r_in       = rv[DW-1:0];
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    el = expect_of(lv, mg);
    er = expect_of(rv, mg);
    if (m && mg > 0) mg--;
    else if (!m && mg < FULL) mg++;
    check_val(req, $signed(l_out), el);
    check_val(req, $signed(r_out), er);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mute_req = 1'b0; frame_tick = 1'b0; l_in = '0; r_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mg = FULL;
    check_val("R1 left", $signed(l_out), 0);
    check_val("R1 right", $signed(r_out), 0);
    tick_chk(1'b0, PROBE, PROBE, "R1 unity gain after reset");
  endtask

  task automatic t_unity();
    tick_chk(1'b0, 123, -456, "R2 R9");
    tick_chk(1'b0, 524287, -524288, "R2 extremes");
    tick_chk(1'b0, 0, -1, "R2 R9 small");
    tick_chk(1'b0, -262144, 262144, "R2 R9 swapped");
  endtask

  task automatic t_idle_hold();
    logic [DW-1:0] lh, rh;
    lh = l_out; rh = r_out;
    @(negedge clk);
    mute_req = 1'b1; l_in = 20'h12345; r_in = 20'h54321;
    repeat (5) @(negedge clk);
    check_val("R10 left hold", int'(l_out), int'(lh));
    check_val("R10 right hold", int'(r_out), int'(rh));
    tick_chk(1'b0, PROBE, PROBE, "R10 gain unchanged by idle mute");
  endtask

  task automatic t_fade_down();
    for (int i = 0; i < FULL; i++) tick_chk(1'b1, PROBE, -PROBE, "R3");
    check_val("R3 gain zero after 1024", mg, 0);
    for (int i = 0; i < 3; i++) tick_chk(1'b1, 524287, -524288, "R4");
  endtask

  task automatic t_fade_up();
    for (int i = 0; i < FULL; i++) tick_chk(1'b0, PROBE, -PROBE, "R5");
    check_val("R5 gain unity after 1024", mg, FULL);
    tick_chk(1'b0, 777, -999, "R5 holds unity");
    tick_chk(1'b0, -5, 5, "R5 holds unity");
  endtask

  task automatic t_round();
    for (int i = 0; i < 512; i++) tick_chk(1'b1, PROBE, PROBE, "R3 partial");
    tick_chk(1'b1, -3, 3, "R8 half gain");
    tick_chk(1'b1, -1, 1, "R8 below one");
    tick_chk(1'b1, -1023, 1023, "R8 fraction");
    tick_chk(1'b1, -524288, 524287, "R8 extremes");
    while (mg < FULL) tick_chk(1'b0, PROBE, PROBE, "R5 return");
  endtask

  task automatic t_rev_down();
    for (int i = 0; i < 300; i++) tick_chk(1'b1, PROBE, PROBE, "R3 partial");
    for (int i = 0; i < 10; i++) tick_chk(1'b0, PROBE, -PROBE, "R6");
    while (mg < FULL) tick_chk(1'b0, PROBE, PROBE, "R6 return");
  endtask

  task automatic t_rev_up();
    for (int i = 0; i < FULL; i++) tick_chk(1'b1, PROBE, PROBE, "R3");
    for (int i = 0; i < 200; i++) tick_chk(1'b0, PROBE, PROBE, "R5 partial");
    for (int i = 0; i < 10; i++) tick_chk(1'b1, PROBE, -PROBE, "R7");
  endtask

  initial begin
    t_reset();
    t_unity();
    t_idle_hold();
    t_fade_down();
    t_fade_up();
    t_round();
    t_rev_down();
    t_rev_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule